// File: doc/BRIEF.md
# Slotted Shared-CAM Lookup Sequencer

This block sequences four packet lookup engines that share one content-addressable memory and one SRAM. A free-running slot counter gives each engine one turn in every four cycles. An engine may change state only on its own turn and holds its state on the other three cycles. Each engine follows a fixed path. It starts idle, may queue for the CAM, loads the CAM, passes two latency stages and then runs compute steps. The compute run ends with an SRAM access.

The CAM is shared through a busy flag. The flag is raised whenever any engine is in its CAM-load state. An engine that wants the CAM enters the load state only if the flag is low on its own turn; otherwise it queues. The SRAM strobe is raised on an engine's turn when it is in the second latency stage or in its final compute step. Because turns never overlap, two engines never use either shared resource at the same time. Per engine, a packet-available input and a compute-done input steer the decisions. Both inputs matter only on that engine's turn.

Top module: `lookup_slot_seq`

## Requirements
- R1: On synchronous active-high reset the slot counter becomes 0 and every engine enters IDLE. With all inputs low, `cam_busy`, `cam_load` and `sram_use` are then low.
- R2: `cur_slot` advances by one every cycle out of reset and wraps from 3 to 0.
- R3: Engine k's state changes only on a clock edge that ends a cycle with `cur_slot == k`. On every other edge it holds.
- R4: State codes are 3 bits: IDLE=0, QUEUED=1, CAMLOAD=2, LAT_A=3, LAT_B=4, COMPUTE=5. Engine k's code sits in `eng_state[3k+2:3k]`. On its turn an IDLE engine stays IDLE if `pkt_avail[k]` is low. If it is high, the engine goes to CAMLOAD when `cam_busy` is low and to QUEUED when it is high.
- R5: On its turn a QUEUED engine stays QUEUED while `cam_busy` is high and moves to CAMLOAD when it is low.
- R6: On the engine's turn, CAMLOAD always moves to LAT_A, LAT_A to LAT_B, and LAT_B to COMPUTE.
- R7: On its turn a COMPUTE engine stays in COMPUTE when `comp_done[k]` is low. When it is high, the engine goes to IDLE if `pkt_avail[k]` is low, and otherwise to CAMLOAD or QUEUED following the rule of R4.
- R8: `cam_load[k]` is high exactly while engine k is in CAMLOAD. `cam_busy` is the OR of all `cam_load` bits. At most one `cam_load` bit is ever high.
- R9: `sram_use[k]` is high exactly on engine k's turn when the engine is in LAT_B, or when it is in COMPUTE with `comp_done[k]` high. At most one `sram_use` bit is ever high.
- R10: An engine never stays in QUEUED for more than 12 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_avail | input | 4 | Per-engine packet-available flag |
| comp_done | input | 4 | Per-engine flag marking the last compute step |
| cur_slot | output | 2 | Current slot number |
| eng_state | output | 12 | Packed 3-bit state code of each engine |
| cam_busy | output | 1 | Some engine is loading the CAM |
| cam_load | output | 4 | Per-engine CAM-load indication |
| sram_use | output | 4 | Per-engine SRAM access strobe |

## Verification
The assertions assume nothing about `pkt_avail` or `comp_done`. Any pattern may appear on any cycle, including a packet that is always present and a compute run that never ends. Only the turn-taking rule is relied on for the exclusion and wait-bound properties. The stimulus therefore draws both inputs freely each cycle. It steps through phases with different biases: sparse packets, short compute runs, saturated demand with immediate completion, and mixed. In the saturated phases all three other engines contend for the CAM, which drives QUEUED toward its 12-cycle limit.

// File: rtl/lkseq_pkg.sv
package lkseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_QUEUED  = 3'd1,
        ST_CAMLOAD = 3'd2,
        ST_LAT_A   = 3'd3,
        ST_LAT_B   = 3'd4,
        ST_COMPUTE = 3'd5
    } eng_st_e;

    localparam int unsigned ST_BITS = 3;

    // Decision taken when a new packet is wanted: load now or queue.
    function automatic eng_st_e claim_cam(logic busy);
        return busy ? ST_QUEUED : ST_CAMLOAD;
    endfunction

    // Next state of one engine, valid only on that engine's turn.
    function automatic eng_st_e step_state(eng_st_e s, logic pkt, logic done, logic busy);
        eng_st_e n;
        case (s)
            ST_IDLE:    n = pkt ? claim_cam(busy) : ST_IDLE;
            ST_QUEUED:  n = claim_cam(busy);
            ST_CAMLOAD: n = ST_LAT_A;
            ST_LAT_A:   n = ST_LAT_B;
            ST_LAT_B:   n = ST_COMPUTE;
            ST_COMPUTE: begin
                if (!done)
                    n = ST_COMPUTE;
                else if (!pkt)
                    n = ST_IDLE;
                else
                    n = claim_cam(busy);
            end
            default:    n = ST_IDLE;
        endcase
        return n;
    endfunction

    // SRAM access happens on the turn spent in LAT_B and on the final compute step.
    function automatic logic sram_turn(eng_st_e s, logic done);
        return (s == ST_LAT_B) || ((s == ST_COMPUTE) && done);
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import lkseq_pkg::*;
#(
    parameter int unsigned N_ENG  = 4,
    parameter int unsigned SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_ENG - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1)); // R2

endmodule

// File: rtl/lookup_engine.sv
module lookup_engine
    import lkseq_pkg::*;
#(
    parameter int unsigned N_ENG  = 4,
    parameter int unsigned SLOT_W = 2,
    parameter int unsigned ENG_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot,
    input  logic              pkt_avail,
    input  logic              comp_done,
    input  logic              cam_busy,
    output logic [2:0]        state_code,
    output logic              cam_load,
    output logic              sram_use
);
    localparam int unsigned WAIT_LIMIT = (N_ENG - 1) * N_ENG;
    localparam int unsigned WCNT_W     = $clog2(WAIT_LIMIT + 2);

    eng_st_e st_q;
    eng_st_e st_d;
    logic    my_turn;

    assign my_turn = (slot == SLOT_W'(ENG_ID));

    always_comb begin
        st_d = st_q;
        if (my_turn)
            st_d = step_state(st_q, pkt_avail, comp_done, cam_busy);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    assign state_code = st_q;
    assign cam_load   = (st_q == ST_CAMLOAD);
    assign sram_use   = my_turn && sram_turn(st_q, comp_done);

    // Consecutive cycles already spent in QUEUED.
    logic [WCNT_W-1:0] qcnt;
    always_ff @(posedge clk) begin
        if (rst || st_q != ST_QUEUED)
            qcnt <= '0;
        else if (qcnt != {WCNT_W{1'b1}})
            qcnt <= qcnt + 1'b1;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !my_turn |=> $stable(state_code)); // R3
    AST_QUEUE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (my_turn && st_q == ST_QUEUED && !cam_busy) |=> state_code == 3'd2); // R5
    AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (my_turn && st_q == ST_CAMLOAD) |=> state_code == 3'd3); // R6
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_QUEUED) |-> (qcnt < WCNT_W'(WAIT_LIMIT))); // R10

endmodule

// File: rtl/share_monitor.sv
module share_monitor
    import lkseq_pkg::*;
#(
    parameter int unsigned N_ENG = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_ENG*ST_BITS-1:0] states,
    input  logic [N_ENG-1:0]         cam_load,
    input  logic [N_ENG-1:0]         sram_use,
    output logic                     cam_busy
);
    logic [N_ENG-1:0] in_load;

    for (genvar k = 0; k < N_ENG; k++) begin : g_dec
        assign in_load[k] = (eng_st_e'(states[k*ST_BITS +: ST_BITS]) == ST_CAMLOAD);
    end

    assign cam_busy = |in_load;

    AST_CAM_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cam_load)); // R8
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
        cam_busy == (cam_load != '0)); // R8
    AST_SRAM_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sram_use)); // R9

endmodule

// File: rtl/lookup_slot_seq.sv
module lookup_slot_seq
    import lkseq_pkg::*;
#(
    parameter int unsigned N_ENG  = 4,
    localparam int unsigned SLOT_W = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_ENG-1:0]         pkt_avail,
    input  logic [N_ENG-1:0]         comp_done,
    output logic [SLOT_W-1:0]        cur_slot,
    output logic [N_ENG*ST_BITS-1:0] eng_state,
    output logic                     cam_busy,
    output logic [N_ENG-1:0]         cam_load,
    output logic [N_ENG-1:0]         sram_use
);
    slot_timer #(.N_ENG(N_ENG), .SLOT_W(SLOT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .slot (cur_slot)
    );

    for (genvar k = 0; k < N_ENG; k++) begin : g_eng
        lookup_engine #(.N_ENG(N_ENG), .SLOT_W(SLOT_W), .ENG_ID(k)) u_eng (
            .clk        (clk),
            .rst        (rst),
            .slot       (cur_slot),
            .pkt_avail  (pkt_avail[k]),
            .comp_done  (comp_done[k]),
            .cam_busy   (cam_busy),
            .state_code (eng_state[k*ST_BITS +: ST_BITS]),
            .cam_load   (cam_load[k]),
            .sram_use   (sram_use[k])
        );
    end

    share_monitor #(.N_ENG(N_ENG)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .states   (eng_state),
        .cam_load (cam_load),
        .sram_use (sram_use),
        .cam_busy (cam_busy)
    );

endmodule

// File: tb/sim_lookup_slot_seq.sv
`timescale 1ns/1ps
module sim_lookup_slot_seq;
    localparam int NE = 4;
    localparam int CYC_PER_PHASE = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NE-1:0] pkt = '0;
    logic [NE-1:0] done = '0;
    logic [1:0] cur_slot;
    logic [NE*3-1:0] eng_state;
    logic cam_busy;
    logic [NE-1:0] cam_load;
    logic [NE-1:0] sram_use;

    always #10 clk = ~clk;

    lookup_slot_seq u0 (
        .clk(clk), .rst(rst), .pkt_avail(pkt), .comp_done(done),
        .cur_slot(cur_slot), .eng_state(eng_state), .cam_busy(cam_busy),
        .cam_load(cam_load), .sram_use(sram_use)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int m_slot;
    int m_st [NE];
    string m_tag [NE];
    int qrun [NE];
    int qmax = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int want_cam(int busy);
        return busy ? 1 : 2;
    endfunction

    // Compare outputs with the model, then advance the model one edge.
    task automatic check_and_step();
        int busy = 0;
        int nx [NE];
        for (int k = 0; k < NE; k++) if (m_st[k] == 2) busy = 1;
        chk("R2 slot", cur_slot, m_slot);
        chk("R8 cam_busy", cam_busy, busy);
        for (int k = 0; k < NE; k++) begin
            int sr;
            chk($sformatf("%s engine%0d state", m_tag[k], k), eng_state[k*3 +: 3], m_st[k]);
            chk($sformatf("R8 cam_load%0d", k), cam_load[k], m_st[k] == 2);
            sr = (k == m_slot) && (m_st[k] == 4 || (m_st[k] == 5 && done[k]));
            chk($sformatf("R9 sram_use%0d", k), sram_use[k], sr);
            // R10 observed from the ports
            if (eng_state[k*3 +: 3] == 3'd1) begin
                qrun[k]++;
                if (qrun[k] > qmax) qmax = qrun[k];
                if (qrun[k] == 13) chk($sformatf("R10 queued run engine%0d", k), qrun[k], 12);
            end else qrun[k] = 0;
        end
        for (int k = 0; k < NE; k++) begin
            nx[k] = m_st[k];
            if (k != m_slot) m_tag[k] = "R3";
            else begin
                case (m_st[k])
                    0: begin m_tag[k] = "R4"; nx[k] = pkt[k] ? want_cam(busy) : 0; end
                    1: begin m_tag[k] = "R5"; nx[k] = want_cam(busy); end
                    2, 3, 4: begin m_tag[k] = "R6"; nx[k] = m_st[k] + 1; end
                    default: begin
                        m_tag[k] = "R7";
                        nx[k] = !done[k] ? 5 : (!pkt[k] ? 0 : want_cam(busy));
                    end
                endcase
            end
        end
        for (int k = 0; k < NE; k++) m_st[k] = nx[k];
        m_slot = (m_slot + 1) % NE;
    endtask

    task automatic run_phase(int pkt_pct, int done_pct);
        for (int c = 0; c < CYC_PER_PHASE; c++) begin
            @(negedge clk);
            for (int k = 0; k < NE; k++) begin
                pkt[k]  = ($urandom % 100) < pkt_pct;
                done[k] = ($urandom % 100) < done_pct;
            end
            #1;
            check_and_step();
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with inputs low
        chk("R1 slot", cur_slot, 0);
        chk("R1 states", eng_state, 0);
        chk("R1 cam_busy", cam_busy, 0);
        chk("R1 cam_load", cam_load, 0);
        chk("R1 sram_use", sram_use, 0);
        rst = 1'b0;
        m_slot = 0;
        for (int k = 0; k < NE; k++) begin m_st[k] = 0; m_tag[k] = "R1"; qrun[k] = 0; end
        check_and_step();
        run_phase(20, 50);   // sparse packets
        run_phase(60, 80);   // short compute runs
        run_phase(100, 100); // saturated demand
        run_phase(100, 40);  // saturated demand, long compute
        run_phase(50, 10);   // mixed, very long compute
        // R10: saturated demand must have produced queueing
        checks++;
        if (qmax == 0) begin
            errors++;
            $display("FAIL R10: actual=%0d expected=nonzero queued run", qmax);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule